// File: doc/BRIEF.md
# Interrupt Enable Masking Controller

This block keeps a processor core's critical-interrupt enable (CE) and debug enable (DE) bits and changes them when the core takes an interrupt. An interrupt can be a debug, critical input, watchdog or machine-check interrupt. For each take it picks the save-register set that receives the interrupted state. It also keeps a small copy of the enable pair for each save set, so that a return-from-critical or return-from-debug instruction can restore the pair. A configuration register decides, for each interrupt class, whether that class also masks the other class's enable. One bit of that register enables a dedicated debug unit. When that bit is low, every clear-control bit is overridden to 1 and debug state is rerouted onto the critical save set.

The block also holds a deferred debug-event request. It is raised when a critical-class or machine-check interrupt is taken while DE is set and critical-interrupt debug events are enabled. The debug handler then runs ahead of the interrupted handler, and that handler resumes with debug disabled.

Every pin is a plain control or status signal. Interrupt takes and instruction decodes are single-cycle strobes that the pipeline has already committed. No data stream crosses the boundary, so no valid/ready handshake and no back-pressure exist.

Top module: `imc_ctrl`

## Requirements
- R1: After reset the configuration register reads 0, and `ce`, `de` and `dbg_evt_req` are 0.
- R2: At most one interrupt is taken per cycle. The priority is machine check, then critical (input or watchdog), then debug. `save_sel` shows the winner in the same cycle: 0 none, 1 critical set, 2 debug set, 3 machine-check set. With no strobe, the enables are unchanged.
- R3: A taken debug interrupt clears `de` on the next edge. It also clears `ce` when the effective debug-masks-CE control (config bit 0) is 1.
- R4: A taken critical input or watchdog interrupt saves {ce,de} into the critical set and clears `ce`. It also clears `de` when the effective critical-masks-DE control (config bit 1) is 1.
- R5: A taken machine check leaves `ce` unchanged. It clears `de` when the effective machine-check-masks-DE control (config bit 2) is 1.
- R6: When the debug-unit enable (config bit 3) is 0, bits 0 to 2 act as 1. A debug take saves into the critical set (`save_sel`=1). `ret_dbg` raises `ill_instr` in the same cycle and has no effect on the enables.
- R7: When the debug-unit enable is 1, a debug take saves into the debug set (`save_sel`=2). `ret_dbg` is legal and restores {ce,de} from the debug set one cycle after decode.
- R8: `ret_crit` restores {ce,de} from the critical set one cycle after decode.
- R9: A critical-class or machine-check take with `dbg_evt_en`=1 and `de`=1 raises `dbg_evt_req` from the next cycle. The request holds until a debug interrupt is taken. That debug take stores DE=0 in its save set.
- R10: Config bits 7 to 4 read 0 and ignore writes. A config write in the same cycle as a take affects only later takes.
- R11: `msr_we` loads `ce`/`de` on the next edge. A take has priority over a return, and a return has priority over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register value |
| msr_we | input | 1 | Direct write of the enable pair |
| msr_ce_in | input | 1 | CE value for a direct write |
| msr_de_in | input | 1 | DE value for a direct write |
| dbg_evt_en | input | 1 | Critical-interrupt debug events enabled |
| take_dbg | input | 1 | Debug interrupt taken |
| take_crit_in | input | 1 | Critical input interrupt taken |
| take_wdog | input | 1 | Watchdog interrupt taken |
| take_mchk | input | 1 | Machine check interrupt taken |
| ret_crit | input | 1 | Return-from-critical decoded |
| ret_dbg | input | 1 | Return-from-debug decoded |
| ce | output | 1 | Critical-interrupt enable |
| de | output | 1 | Debug enable |
| save_sel | output | 2 | Save set chosen by this cycle's take |
| ill_instr | output | 1 | Return-from-debug is illegal this cycle |
| dbg_evt_req | output | 1 | Deferred debug event pending |

## Verification
The assertions assume that `ret_crit` and `ret_dbg` never arrive together. They also assume that the take strobes reflect interrupts the pipeline has committed, whatever the current enables are. The bench drives at most one return strobe per cycle. It resets before every case so that the pending request and the save copies start known. It sweeps every configuration value, starting enable pair, strobe combination and event-enable setting, and expects the arbitration to sort out simultaneous takes.

// File: rtl/imc_pkg.sv
package imc_pkg;
  localparam int CFG_W   = 8;
  localparam int CFG_DCE = 0;
  localparam int CFG_CDE = 1;
  localparam int CFG_MDE = 2;
  localparam int CFG_UEN = 3;
  localparam int CFG_USED = 4;
  localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'((1 << CFG_USED) - 1);

  typedef enum logic [1:0] {
    SAVE_NONE = 2'd0,
    SAVE_CRIT = 2'd1,
    SAVE_DBG  = 2'd2,
    SAVE_MCHK = 2'd3
  } save_sel_e;

  typedef struct packed {
    logic ce;
    logic de;
  } en_pair_t;

  typedef struct packed {
    logic dbg_clr_ce;
    logic crit_clr_de;
    logic mchk_clr_de;
    logic unit_en;
  } ctl_t;

  typedef struct packed {
    logic mchk;
    logic crit;
    logic dbg;
  } grant_t;
endpackage

// File: rtl/imc_cfg_reg.sv
module imc_cfg_reg
  import imc_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output ctl_t         ctl
);
  localparam logic [W-1:0] MASK = W'(CFG_MASK);

  logic [W-1:0] q;

  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & MASK;
  end

  assign rdata = q;

  always_comb begin
    ctl.unit_en     = q[CFG_UEN];
    ctl.dbg_clr_ce  = q[CFG_DCE] | ~q[CFG_UEN];
    ctl.crit_clr_de = q[CFG_CDE] | ~q[CFG_UEN];
    ctl.mchk_clr_de = q[CFG_MDE] | ~q[CFG_UEN];
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(rdata)); // R10
endmodule

// File: rtl/imc_take_arb.sv
module imc_take_arb
  import imc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      take_dbg,
  input  logic      take_crit_in,
  input  logic      take_wdog,
  input  logic      take_mchk,
  input  logic      unit_en,
  output grant_t    grant,
  output save_sel_e sel
);
  always_comb begin
    grant = '0;
    sel   = SAVE_NONE;
    if (take_mchk) begin
      grant.mchk = 1'b1;
      sel        = SAVE_MCHK;
    end else if (take_crit_in || take_wdog) begin
      grant.crit = 1'b1;
      sel        = SAVE_CRIT;
    end else if (take_dbg) begin
      grant.dbg  = 1'b1;
      sel        = unit_en ? SAVE_DBG : SAVE_CRIT;
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R2
  AST_MCHK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    take_mchk |-> (grant.mchk && !grant.crit && !grant.dbg)); // R2
endmodule

// File: rtl/imc_enable_state.sv
module imc_enable_state
  import imc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  grant_t grant,
  input  ctl_t   ctl,
  input  logic   evt_en,
  input  logic   msr_we,
  input  logic   msr_ce_in,
  input  logic   msr_de_in,
  input  logic   ret_crit,
  input  logic   ret_dbg,
  output logic   ce,
  output logic   de,
  output logic   pend,
  output logic   ill
);
  en_pair_t crit_sv;
  en_pair_t dbg_sv;
  en_pair_t dbg_saved;

  assign ill = ret_dbg & ~ctl.unit_en;

  always_comb begin
    dbg_saved.ce = ce;
    dbg_saved.de = pend ? 1'b0 : de;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce      <= 1'b0;
      de      <= 1'b0;
      pend    <= 1'b0;
      crit_sv <= '0;
      dbg_sv  <= '0;
    end else if (grant.mchk) begin
      if (ctl.mchk_clr_de) de <= 1'b0;
      pend <= pend | (evt_en & de);
    end else if (grant.crit) begin
      crit_sv <= '{ce: ce, de: de};
      ce      <= 1'b0;
      if (ctl.crit_clr_de) de <= 1'b0;
      pend <= pend | (evt_en & de);
    end else if (grant.dbg) begin
      if (ctl.unit_en) dbg_sv  <= dbg_saved;
      else             crit_sv <= dbg_saved;
      if (ctl.dbg_clr_ce) ce <= 1'b0;
      de   <= 1'b0;
      pend <= 1'b0;
    end else if (ret_crit) begin
      ce <= crit_sv.ce;
      de <= crit_sv.de;
    end else if (ret_dbg && ctl.unit_en) begin
      ce <= dbg_sv.ce;
      de <= dbg_sv.de;
    end else if (msr_we) begin
      ce <= msr_ce_in;
      de <= msr_de_in;
    end
  end

  AST_CRIT_CLEARS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    grant.crit |=> !ce); // R4
  AST_MCHK_KEEPS_CE: assert property (@(posedge clk) disable iff (!rst_n)
    grant.mchk |=> $stable(ce)); // R5
  AST_DBG_CLEARS_DE: assert property (@(posedge clk) disable iff (!rst_n)
    grant.dbg |=> (!de && !pend)); // R3
  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant.crit || grant.mchk) && evt_en && de) |=> pend); // R9
  AST_ILLEGAL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (ill && grant == '0 && !ret_crit && !msr_we) |=> ($stable(ce) && $stable(de))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && !ret_crit && !ret_dbg && !msr_we) |=> ($stable(ce) && $stable(de))); // R11
  AST_RET_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_crit && ret_dbg)); // R8
endmodule

// File: rtl/imc_ctrl.sv
module imc_ctrl
  import imc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             msr_we,
  input  logic             msr_ce_in,
  input  logic             msr_de_in,
  input  logic             dbg_evt_en,
  input  logic             take_dbg,
  input  logic             take_crit_in,
  input  logic             take_wdog,
  input  logic             take_mchk,
  input  logic             ret_crit,
  input  logic             ret_dbg,
  output logic             ce,
  output logic             de,
  output logic [1:0]       save_sel,
  output logic             ill_instr,
  output logic             dbg_evt_req
);
  ctl_t      ctl;
  grant_t    grant;
  save_sel_e sel;

  imc_cfg_reg #(.W(CFG_W)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .ctl   (ctl)
  );

  imc_take_arb u_arb (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_dbg     (take_dbg),
    .take_crit_in (take_crit_in),
    .take_wdog    (take_wdog),
    .take_mchk    (take_mchk),
    .unit_en      (ctl.unit_en),
    .grant        (grant),
    .sel          (sel)
  );

  imc_enable_state u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .ctl       (ctl),
    .evt_en    (dbg_evt_en),
    .msr_we    (msr_we),
    .msr_ce_in (msr_ce_in),
    .msr_de_in (msr_de_in),
    .ret_crit  (ret_crit),
    .ret_dbg   (ret_dbg),
    .ce        (ce),
    .de        (de),
    .pend      (dbg_evt_req),
    .ill       (ill_instr)
  );

  assign save_sel = sel;
endmodule

// File: tb/imc_ctrl_bench.sv
module imc_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       msr_we, msr_ce_in, msr_de_in, dbg_evt_en;
  logic       take_dbg, take_crit_in, take_wdog, take_mchk;
  logic       ret_crit, ret_dbg;
  logic       ce, de, ill_instr, dbg_evt_req;
  logic [1:0] save_sel;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  imc_ctrl u_imc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .msr_we(msr_we), .msr_ce_in(msr_ce_in),
    .msr_de_in(msr_de_in), .dbg_evt_en(dbg_evt_en), .take_dbg(take_dbg),
    .take_crit_in(take_crit_in), .take_wdog(take_wdog), .take_mchk(take_mchk),
    .ret_crit(ret_crit), .ret_dbg(ret_dbg), .ce(ce), .de(de),
    .save_sel(save_sel), .ill_instr(ill_instr), .dbg_evt_req(dbg_evt_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    cfg_we = 0; cfg_wdata = 0; msr_we = 0; msr_ce_in = 0; msr_de_in = 0;
    take_dbg = 0; take_crit_in = 0; take_wdog = 0; take_mchk = 0;
    ret_crit = 0; ret_dbg = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    cyc();
    rst_n = 1;
  endtask

  task automatic run_case(input int cfg, input int msr, input int tk, input int ev);
    int en, dce, cde, mde;
    int e_ce, e_de, e_pend, c_ce, c_de, d_ce, d_de, sel;
    string r;
    en  = (cfg >> 3) & 1;
    dce = en ? (cfg & 1) : 1;
    cde = en ? ((cfg >> 1) & 1) : 1;
    mde = en ? ((cfg >> 2) & 1) : 1;
    e_ce = msr & 1; e_de = (msr >> 1) & 1; e_pend = 0;
    c_ce = 0; c_de = 0; d_ce = 0; d_de = 0;
    do_reset();
    cfg_we = 1; cfg_wdata = 8'(cfg | 8'hF0);
    cyc();
    cfg_we = 0;
    chk("R10 reserved bits", int'(cfg_rdata), cfg);
    msr_we = 1; msr_ce_in = e_ce[0]; msr_de_in = e_de[0];
    cyc();
    msr_we = 0;
    chk("R11 ce write", int'(ce), e_ce);
    chk("R11 de write", int'(de), e_de);
    // phase A: arbitrated take
    dbg_evt_en = ev[0];
    take_dbg = tk[0]; take_crit_in = tk[1]; take_wdog = tk[2]; take_mchk = tk[3];
    if (tk[3]) begin
      sel = 3; r = "R5";
      e_pend = ev & e_de;
      if (mde) e_de = 0;
    end else if (tk[1] | tk[2]) begin
      sel = 1; r = "R4";
      c_ce = e_ce; c_de = e_de;
      e_pend = ev & e_de;
      e_ce = 0;
      if (cde) e_de = 0;
    end else if (tk[0]) begin
      sel = en ? 2 : 1; r = "R3";
      if (en) begin d_ce = e_ce; d_de = e_de; end
      else begin c_ce = e_ce; c_de = e_de; end
      if (dce) e_ce = 0;
      e_de = 0;
    end else begin
      sel = 0; r = "R2";
    end
    #1;
    chk("R2 save_sel", int'(save_sel), sel);
    cyc();
    take_dbg = 0; take_crit_in = 0; take_wdog = 0; take_mchk = 0;
    chk({r, " ce after take"}, int'(ce), e_ce);
    chk({r, " de after take"}, int'(de), e_de);
    chk("R9 request", int'(dbg_evt_req), e_pend);
    // phase B: debug take
    take_dbg = 1;
    #1;
    chk(en ? "R7 debug sel" : "R6 debug sel", int'(save_sel), en ? 2 : 1);
    if (en) begin d_ce = e_ce; d_de = e_pend ? 0 : e_de; end
    else begin c_ce = e_ce; c_de = e_pend ? 0 : e_de; end
    if (dce) e_ce = 0;
    e_de = 0;
    cyc();
    take_dbg = 0;
    chk("R3 ce after debug", int'(ce), e_ce);
    chk("R3 de after debug", int'(de), e_de);
    chk("R9 request cleared", int'(dbg_evt_req), 0);
    // phase C: returns
    ret_dbg = 1;
    #1;
    chk(en ? "R7 legal" : "R6 illegal", int'(ill_instr), en ? 0 : 1);
    cyc();
    ret_dbg = 0;
    if (en) begin
      chk("R7 restore ce", int'(ce), d_ce);
      chk("R9 R7 restore de", int'(de), d_de);
    end else begin
      chk("R6 ce unchanged", int'(ce), e_ce);
      chk("R6 de unchanged", int'(de), e_de);
      ret_crit = 1;
      cyc();
      ret_crit = 0;
      chk("R8 restore ce", int'(ce), c_ce);
      chk("R9 R8 restore de", int'(de), c_de);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    dbg_evt_en = 0;
    rst_n = 0;
    @(negedge clk);
    cyc();
    rst_n = 1;
    chk("R1 cfg", int'(cfg_rdata), 0);
    chk("R1 ce", int'(ce), 0);
    chk("R1 de", int'(de), 0);
    chk("R1 request", int'(dbg_evt_req), 0);

    for (int cfg = 0; cfg < 16; cfg++)
      for (int msr = 0; msr < 4; msr++)
        for (int tk = 0; tk < 16; tk++)
          for (int ev = 0; ev < 2; ev++)
            run_case(cfg, msr, tk, ev);

    // config write in same cycle as a take uses the old value
    do_reset();
    cfg_we = 1; cfg_wdata = 8'h08;
    cyc();
    cfg_we = 0;
    msr_we = 1; msr_ce_in = 1; msr_de_in = 1;
    cyc();
    msr_we = 0;
    take_crit_in = 1; cfg_we = 1; cfg_wdata = 8'h0F;
    cyc();
    take_crit_in = 0; cfg_we = 0;
    chk("R10 old cfg used", int'(de), 1);
    chk("R10 new cfg stored", int'(cfg_rdata), 8'h0F);
    take_wdog = 1;
    cyc();
    take_wdog = 0;
    chk("R10 new cfg later", int'(de), 0);

    // take beats a simultaneous direct write
    msr_we = 1; msr_ce_in = 1; msr_de_in = 1; take_mchk = 1;
    cyc();
    msr_we = 0; take_mchk = 0;
    chk("R11 take over write de", int'(de), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule